// File: doc/BRIEF.md
# AHB to APB Bridge

This block is an AHB slave that turns pipelined AHB single transfers into two-phase APB transfers. It is the only master on its APB segment. When an AHB address phase is accepted, the bridge captures the address and direction and decodes the address into one of a fixed number of peripheral slots. It then runs a setup cycle and an access cycle on the APB. The access cycle is stretched for as long as the addressed peripheral holds PREADY low. HREADY stays low from acceptance until that access finishes, so no more than one APB access is ever in flight. Bursts pass through as back-to-back single transfers: a new address phase presented in the completing cycle starts the next setup cycle at once.

The request filter rejects any command whose address falls outside every slot. Such a command never reaches the APB and is answered with the two-cycle AHB ERROR response. A peripheral that signals a slave error at the end of its access gets the same response. IDLE and BUSY transfers, and cycles without HSEL, are answered OKAY with no wait state and leave the APB untouched. The whole block runs on one clock with a synchronous active-low reset.

Top module: `ahb_apb_bridge`

## Requirements
- R1: During and after a synchronous reset (rst_n low at a rising edge), hready_out is 1, hresp is 0 (OKAY), psel is all zero and penable is 0.
- R2: An address phase is taken only when hsel=1, hready_in=1 and htrans is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01) or hsel=0 produce no APB activity, hready_out=1 and hresp=0.
- R3: In the cycle after a taken address phase to a mapped slot, exactly one psel bit is high and penable is 0. This is the setup cycle.
- R4: The cycle after the setup cycle has penable=1 with psel unchanged. It repeats, with psel, paddr and pwrite unchanged, for as long as pready is 0.
- R5: paddr equals the captured haddr and pwrite equals the captured hwrite, unchanged from the setup cycle until the access completes.
- R6: Slot k (k < NUM_SLOTS) is addressed when haddr[ADDR_W-1:SLOT_SHIFT] equals k, and it drives psel[k]. At most one psel bit is ever high.
- R7: A taken address phase whose slot field is NUM_SLOTS or greater never raises psel. It gives one cycle of hresp=1 with hready_out=0, followed by one cycle of hresp=1 with hready_out=1.
- R8: hready_out is 0 from the setup cycle until the access cycle in which pready=1, and it is 1 in that cycle when pslverr=0.
- R9: During a write access, pwdata equals the hwdata driven by the AHB master in the data phase.
- R10: In the completing cycle of a read access without error, hrdata equals prdata and hresp is 0.
- R11: An access that completes with pready=1 and pslverr=1 gives the same two-cycle ERROR response as R7.
- R12: An address phase taken in the completing cycle of an access starts the next setup cycle on the next clock, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both buses |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Bridge selected on the AHB |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB direction, 1 = write |
| hwdata | input | DATA_W | AHB write data (data phase) |
| hready_in | input | 1 | AHB bus ready seen by all slaves |
| hrdata | output | DATA_W | AHB read data |
| hready_out | output | 1 | Bridge ready / transfer done |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| paddr | output | ADDR_W | APB address |
| psel | output | NUM_SLOTS | One-hot APB peripheral select |
| penable | output | 1 | APB access-phase strobe |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB peripheral ready |
| pslverr | input | 1 | APB peripheral error |

## Verification
The bench uses the defaults: a 16-bit address, a 12-bit slot offset, four slots and 32-bit data. This leaves twelve of the sixteen slot-field values unmapped, so rejected commands are easy to reach next to valid ones. With these sizes the bench can put every slot, unmapped addresses, zero and multi-cycle peripheral waits, slave errors and back-to-back SEQ bursts into short runs. Each cycle is compared with a behavioural model.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
// Shared codes for the AHB to APB bridge.
// Assumes: AHB transfer-type encoding IDLE=00, BUSY=01, NONSEQ=10, SEQ=11.
package bridge_pkg;
    localparam logic [1:0] TRANS_IDLE   = 2'b00;
    localparam logic [1:0] TRANS_BUSY   = 2'b01;
    localparam logic [1:0] TRANS_NONSEQ = 2'b10;
    localparam logic [1:0] TRANS_SEQ    = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,      // no APB access, AHB side ready
        ST_SETUP,     // APB setup cycle
        ST_ACCESS,    // APB access cycle, repeats while pready low
        ST_ERR_WAIT,  // first ERROR cycle, hready low
        ST_ERR_DONE   // second ERROR cycle, hready high
    } bridge_state_e;
endpackage

// File: rtl/bridge_slot_decode.sv
`timescale 1ns/1ps
// Slot decoder: turns the upper address field into a one-hot slot vector.
// Assumes: slot k owns the field value k; values >= NUM_SLOTS are unmapped.
module bridge_slot_decode #(
    parameter int FIELD_W   = 4,
    parameter int NUM_SLOTS = 4
) (
    input  logic [FIELD_W-1:0]   slot_field,
    output logic [NUM_SLOTS-1:0] slot_hit,
    output logic                 slot_mapped
);
    // One comparator per slot.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign slot_hit[k] = (slot_field == FIELD_W'(k));
    end

    // The address is valid when any slot matched.
    assign slot_mapped = |slot_hit;
endmodule

// File: rtl/bridge_apb_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: runs one APB access, or one ERROR response, per
// accepted AHB request, and captures address and control at acceptance.
// Assumes: take is only raised while the bridge reports ready on the AHB.
module bridge_apb_seq
    import bridge_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 mapped,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic [ADDR_W-1:0]    haddr,
    input  logic                 hwrite,
    input  logic                 pready,
    input  logic                 pslverr,
    output bridge_state_e        state,
    output logic [NUM_SLOTS-1:0] sel_q,
    output logic [ADDR_W-1:0]    addr_q,
    output logic                 write_q
);
    bridge_state_e state_nx;
    bridge_state_e start_tgt;
    logic          capture;

    // Next state: a taken request goes to setup if mapped, else to error.
    always_comb begin
        start_tgt = mapped ? ST_SETUP : ST_ERR_WAIT;
        state_nx  = state;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE, ST_ERR_DONE: begin
                state_nx = take ? start_tgt : ST_IDLE;
                capture  = take & mapped;
            end
            ST_SETUP: state_nx = ST_ACCESS;
            ST_ACCESS: begin
                if (pready) begin
                    if (pslverr) begin
                        state_nx = ST_ERR_WAIT;
                    end else begin
                        state_nx = take ? start_tgt : ST_IDLE;
                        capture  = take & mapped;
                    end
                end
            end
            ST_ERR_WAIT: state_nx = ST_ERR_DONE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register and capture of address, direction and slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel_q   <= '0;
            addr_q  <= '0;
            write_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (capture) begin
                sel_q   <= hit;
                addr_q  <= haddr;
                write_q <= hwrite;
            end
        end
    end
endmodule

// File: rtl/ahb_apb_bridge.sv
`timescale 1ns/1ps
// AHB to APB bridge top: filters AHB requests, decodes the peripheral
// slot and drives a single APB access at a time.
// Assumes: one clock for both buses; hwdata is held by the master while
// hready is low, so it is passed straight to pwdata.
module ahb_apb_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int SLOT_SHIFT = 12,
    parameter int NUM_SLOTS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsel,
    input  logic [ADDR_W-1:0]    haddr,
    input  logic [1:0]           htrans,
    input  logic                 hwrite,
    input  logic [DATA_W-1:0]    hwdata,
    input  logic                 hready_in,
    output logic [DATA_W-1:0]    hrdata,
    output logic                 hready_out,
    output logic                 hresp,
    output logic [ADDR_W-1:0]    paddr,
    output logic [NUM_SLOTS-1:0] psel,
    output logic                 penable,
    output logic                 pwrite,
    output logic [DATA_W-1:0]    pwdata,
    input  logic [DATA_W-1:0]    prdata,
    input  logic                 pready,
    input  logic                 pslverr
);
    localparam int FIELD_W = ADDR_W - SLOT_SHIFT;

    logic [NUM_SLOTS-1:0] hit;
    logic                 mapped;
    logic                 take;
    bridge_state_e        state;
    logic [NUM_SLOTS-1:0] sel_q;
    logic [ADDR_W-1:0]    addr_q;
    logic                 write_q;
    logic                 apb_busy;

    bridge_slot_decode #(
        .FIELD_W   (FIELD_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_decode (
        .slot_field  (haddr[ADDR_W-1:SLOT_SHIFT]),
        .slot_hit    (hit),
        .slot_mapped (mapped)
    );

    // Request filter: active transfer type, selected, bus and bridge ready.
    assign take = hsel & hready_in & hready_out &
                  ((htrans == TRANS_NONSEQ) | (htrans == TRANS_SEQ));

    bridge_apb_seq #(
        .ADDR_W    (ADDR_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .mapped  (mapped),
        .hit     (hit),
        .haddr   (haddr),
        .hwrite  (hwrite),
        .pready  (pready),
        .pslverr (pslverr),
        .state   (state),
        .sel_q   (sel_q),
        .addr_q  (addr_q),
        .write_q (write_q)
    );

    // APB drive: selects only during setup and access.
    always_comb begin
        apb_busy = (state == ST_SETUP) | (state == ST_ACCESS);
        psel     = apb_busy ? sel_q : '0;
        penable  = (state == ST_ACCESS);
        paddr    = addr_q;
        pwrite   = write_q;
        pwdata   = hwdata;
    end

    // AHB response: ready, error and read data returned from the access.
    always_comb begin
        hresp      = (state == ST_ERR_WAIT) | (state == ST_ERR_DONE);
        hready_out = (state == ST_IDLE) | (state == ST_ERR_DONE) |
                     ((state == ST_ACCESS) & pready & ~pslverr);
        hrdata     = ((state == ST_ACCESS) & ~write_q) ? prdata : '0;
    end
endmodule

// File: rtl/ahb_apb_bridge_checker.sv
`timescale 1ns/1ps
// Protocol checker for ahb_apb_bridge, attached by bind below.
// Assumes: synchronous active-low reset; only top-level ports observed.
module ahb_apb_bridge_checker #(
    parameter int ADDR_W    = 16,
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hready_out,
    input logic                 hresp,
    input logic [ADDR_W-1:0]    paddr,
    input logic [NUM_SLOTS-1:0] psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic                 pready,
    input logic                 pslverr
);
    // R6: never more than one select.
    a_r6_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel));

    // R3: a setup cycle is followed by an access cycle to the same slot.
    a_r3_setup_to_access: assert property (@(posedge clk) disable iff (!rst_n)
        (psel != '0 && !penable) |=> (penable && $stable(psel)));

    // R4: a waited access repeats with select unchanged.
    a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && !pready) |=> (penable && $stable(psel)));

    // R5: address and direction stay put through the access phase.
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (psel != '0 && !(penable && pready)) |=> ($stable(paddr) && $stable(pwrite)));

    // R4: enable only together with a select.
    a_r4_enable_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> (psel != '0));

    // R8: AHB is held while the setup cycle runs.
    a_r8_hold_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (psel != '0 && !penable) |-> !hready_out);

    // R7: first ERROR cycle is followed by the ready ERROR cycle.
    a_r7_err_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready_out) |=> (hresp && hready_out));

    // R11: a slave error at completion starts the ERROR response.
    a_r11_slverr_response: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && pready && pslverr) |=> (hresp && !hready_out && psel == '0));
endmodule

bind ahb_apb_bridge ahb_apb_bridge_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_SLOTS (NUM_SLOTS)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hready_out (hready_out),
    .hresp      (hresp),
    .paddr      (paddr),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .pready     (pready),
    .pslverr    (pslverr)
);

// File: tb/tb_ahb_apb_bridge.sv
`timescale 1ns/1ps
module tb_ahb_apb_bridge;
    localparam int ADDR_W = 16, DATA_W = 32, SLOT_SHIFT = 12, NUM_SLOTS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hsel = 1'b0, hwrite = 1'b0;
    logic [ADDR_W-1:0] haddr = '0;
    logic [1:0] htrans = 2'b00;
    logic [DATA_W-1:0] hwdata = '0;
    logic hready_in;
    logic [DATA_W-1:0] hrdata, pwdata, prdata;
    logic hready_out, hresp, penable, pwrite;
    logic [ADDR_W-1:0] paddr;
    logic [NUM_SLOTS-1:0] psel;
    logic pready = 1'b0, pslverr = 1'b0;

    int checks = 0, fails = 0, cyc = 0;
    int wait_req = 0, acc = 0;
    bit err_req = 0, cmp_on = 0, done = 0;

    // Behavioural model: 0 idle, 1 setup, 2 access, 3 error-1, 4 error-2.
    int m_st = 0, m_slot = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    bit m_wr = 0;
    logic [DATA_W-1:0] m_wdata = '0;

    assign hready_in = hready_out;
    assign prdata = {paddr, ~paddr};

    always #2 clk = ~clk;

    ahb_apb_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_SHIFT(SLOT_SHIFT),
                     .NUM_SLOTS(NUM_SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hready_in(hready_in), .hrdata(hrdata),
        .hready_out(hready_out), .hresp(hresp), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr));

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit m_ready();
        return (m_st == 0) || (m_st == 4) || (m_st == 2 && pready && !pslverr);
    endfunction

    // Peripheral: waits wait_req cycles in access, then ready; error on request.
    always @(negedge clk) begin
        if (psel != '0 && penable) begin
            pready  = (acc >= wait_req);
            pslverr = pready && err_req;
            acc++;
        end else begin
            pready = 1'b0; pslverr = 1'b0; acc = 0;
        end
    end

    // Model advance at each rising edge.
    always @(posedge clk) begin
        bit tk, rdy;
        int sl;
        rdy = m_ready();
        tk  = hsel && hready_in && htrans[1] && rdy;
        sl  = int'(haddr >> SLOT_SHIFT);
        if (!rst_n) m_st = 0;
        else begin
            if (m_st == 1) m_wdata = hwdata;
            case (m_st)
                1: m_st = 2;
                3: m_st = 4;
                2: if (pready) m_st = pslverr ? 3 : 0;
                default: m_st = 0;
            endcase
            if (tk && m_st == 0) begin
                if (sl < NUM_SLOTS) begin
                    m_st = 1; m_slot = sl; m_addr = haddr; m_wr = hwrite;
                end else m_st = 3;
            end
        end
    end

    // Per-cycle compare, after peripheral and driver have settled.
    always @(negedge clk) begin
        #1.5;
        if (cmp_on && rst_n) begin
            logic [NUM_SLOTS-1:0] es;
            es = (m_st == 1 || m_st == 2) ? NUM_SLOTS'(1 << m_slot) : '0;
            chk(psel == es, "R3/R6", "psel", 32'(psel), 32'(es));
            chk($countones(psel) <= 1, "R6", "onehot", 32'(psel), 32'd1);
            chk(penable == (m_st == 2), "R4", "penable", 32'(penable), 32'(m_st == 2));
            if (es != '0) begin
                chk(paddr == m_addr, "R5", "paddr", 32'(paddr), 32'(m_addr));
                chk(pwrite == m_wr, "R5", "pwrite", 32'(pwrite), 32'(m_wr));
            end
            if (m_st == 2 && m_wr)
                chk(pwdata == m_wdata, "R9", "pwdata", pwdata, m_wdata);
            chk(hready_out == m_ready(), "R8", "hready", 32'(hready_out), 32'(m_ready()));
            chk(hresp == (m_st == 3 || m_st == 4), "R7/R11", "hresp",
                32'(hresp), 32'(m_st == 3 || m_st == 4));
            if (m_st == 2 && pready && !pslverr && !m_wr)
                chk(hrdata == {m_addr, ~m_addr}, "R10", "hrdata", hrdata, {m_addr, ~m_addr});
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // One AHB transfer; returns at negedge+1 of the completing cycle.
    task automatic xfer(logic [ADDR_W-1:0] a, bit wr, logic [DATA_W-1:0] wd,
                        logic [1:0] tr, int waits, bit err);
        wait_req = waits; err_req = err;
        hsel = 1'b1; haddr = a; hwrite = wr; htrans = tr;
        tick();
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        while (!hready_out) tick();
    endtask

    task automatic park();
        hsel = 1'b0; htrans = 2'b00; tick(); tick();
    endtask

    task automatic quiet_phase(bit s, logic [1:0] tr);
        hsel = s; haddr = 16'h1000; htrans = tr; hwrite = 1'b1;
        tick();
        chk(psel == '0 && hready_out && !hresp, "R2", "ignored phase",
            {psel, hready_out, hresp}, {4'b0, 1'b1, 1'b0});
        hsel = 1'b0; htrans = 2'b00;
    endtask

    function automatic string summary_line();
        return $sformatf("%0d/%0d checks passed", checks - fails, checks);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
            $display("%s", summary_line());
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk(hready_out && !hresp && psel == '0 && !penable, "R1", "reset state",
            {psel, hready_out, hresp, penable}, {4'b0, 1'b1, 1'b0, 1'b0});
        rst_n = 1'b1;
        cmp_on = 1;
        tick();
        // R2: ignored phases.
        quiet_phase(1'b1, 2'b00);
        quiet_phase(1'b1, 2'b01);
        quiet_phase(1'b0, 2'b10);
        park();
        // Single transfers to every slot, various waits.
        xfer(16'h0010, 1'b1, 32'hDEAD_0001, 2'b10, 0, 0); park();
        xfer(16'h1024, 1'b0, 32'h0,         2'b10, 2, 0); park();
        xfer(16'h2ABC, 1'b1, 32'h1234_5678, 2'b10, 3, 0); park();
        xfer(16'h3FFC, 1'b0, 32'h0,         2'b10, 0, 0); park();
        // R7: unmapped addresses.
        xfer(16'h4000, 1'b1, 32'hBAD0_0000, 2'b10, 0, 0); park();
        xfer(16'hF123, 1'b0, 32'h0,         2'b10, 0, 0); park();
        // R11: slave error on read and write.
        xfer(16'h1100, 1'b0, 32'h0,         2'b10, 1, 1); park();
        xfer(16'h2200, 1'b1, 32'hCAFE_F00D, 2'b10, 0, 1); park();
        // R12: back-to-back burst, then a start right after completion.
        xfer(16'h0100, 1'b1, 32'hA000_0001, 2'b10, 0, 0);
        xfer(16'h0104, 1'b1, 32'hA000_0002, 2'b11, 2, 0);
        hsel = 1'b1; haddr = 16'h0108; hwrite = 1'b0; htrans = 2'b11;
        wait_req = 1; err_req = 0;
        tick();
        chk(psel == 4'b0001 && !penable, "R12", "setup right after completion",
            {psel, penable}, {4'b0001, 1'b0});
        hsel = 1'b0; htrans = 2'b00;
        while (!hready_out) tick();
        xfer(16'h310C, 1'b0, 32'h0, 2'b11, 0, 0);
        xfer(16'h9000, 1'b1, 32'h0, 2'b10, 0, 0);
        park();
        xfer(16'h2010, 1'b1, 32'h5555_AAAA, 2'b10, 0, 0); park();
        repeat (4) tick();
        done = 1;
        $display("%s", summary_line());
        $finish;
    end
endmodule